// File: doc/BRIEF.md
# Mailbox Command Dispatcher

A register-mapped command mailbox sitting between a host register port and a set of command handlers. The host places a command word in the command register, fills a small payload buffer, and rings the doorbell by writing bit 0 of the control register. The block then owns the mailbox. It splits the opcode into a command set and a command, and looks the opcode up in a parameter table of supported opcodes. It checks the input length against that opcode's expected length and, if the command is accepted, starts the matching handler with a one-cycle start pulse.

When the handler signals done, the block writes the output length into the command register with the opcode fields zeroed, and writes the return code into the status register. One cycle later it drops the doorbell. The host polls the doorbell to learn that the result is ready. Commands that are rejected never reach a handler and complete through the same write-back path.

Register map (word addresses on `host_addr`): 0 control (bit 0 doorbell), 1 command, 2 status, 4 to 4+PAY_WORDS-1 payload. Command register layout: bits [7:0] command, [15:8] command set, [31:16] length. Status register: bits [7:0] return code.

Top module: `mbox_dispatch`

## Requirements
- R1: After reset the doorbell, command register, status register and payload read as zero; writing control with bit 0 set while idle sets the doorbell.
- R2: The opcode is the command register's bits [15:0], set in [15:8] and command in [7:0]; an opcode absent from the table completes with return code 0x03, output length 0, and no handler start.
- R3: A listed opcode whose input length differs from its fixed expected length completes with return code 0x16, output length 0, and no handler start.
- R4: A table entry whose expected length is 0xFFFF accepts any input length.
- R5: An accepted command raises hs_start for exactly one cycle, two clock edges after the doorbell write, with hs_opcode and hs_in_len holding the command's opcode and input length.
- R6: On handler done the command register becomes {output length, 16'h0000} and the status register takes the handler's return code (0x00 success, 0x02 invalid input and 0x04 internal error pass through).
- R7: The doorbell falls one cycle after the command and status registers are written, never in the same cycle.
- R8: While the doorbell is set, host writes to the command register, the payload and the control register have no effect.
- R9: A handler output length above the payload buffer size (4*PAY_WORDS bytes) is clamped to that size and the return code becomes 0x04; a length equal to the size is kept.
- R10: hs_done outside a pending handler call has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| doorbell | output | 1 | Doorbell state, high while a command is owned by the block |
| hs_start | output | 1 | One-cycle handler start pulse |
| hs_opcode | output | 16 | Opcode of the started command |
| hs_in_len | output | 16 | Input length of the started command |
| hs_done | input | 1 | Handler completion pulse |
| hs_rc | input | 8 | Handler return code |
| hs_out_len | input | 16 | Handler output length in bytes |

## Verification
The hardest case to reach is a host write that lands while a handler call is pending: it needs the handler stub to hold off its done pulse while the bench issues command, payload and doorbell writes. The stub waits for the start pulse, pokes all three registers, then answers. Afterwards the payload and command readback must show the pre-command payload and the handler's result. The clamp boundary needs the stub to report output lengths exactly at the buffer size and one byte above it.

// File: rtl/mbox_dispatch.sv
module mbox_dispatch #(
  parameter int PAY_WORDS = 8,
  parameter int AW = 4,
  parameter int NUM_OPS = 4,
  parameter logic [NUM_OPS*16-1:0] OP_CODES = {16'h4102, 16'h0301, 16'h0101, 16'h0100},
  parameter logic [NUM_OPS*16-1:0] OP_INLEN = {16'd8, 16'd8, 16'hFFFF, 16'd1}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          doorbell,
  output logic          hs_start,
  output logic [15:0]   hs_opcode,
  output logic [15:0]   hs_in_len,
  input  logic          hs_done,
  input  logic [7:0]    hs_rc,
  input  logic [15:0]   hs_out_len
);
  localparam int PAY_BASE  = 4;
  localparam int PAY_BYTES = PAY_WORDS * 4;
  localparam int PW        = (PAY_WORDS > 1) ? $clog2(PAY_WORDS) : 1;
  localparam logic [7:0] RC_INTERNAL = 8'h04;
  localparam logic [7:0] RC_UNSUP    = 8'h03;
  localparam logic [7:0] RC_BADLEN   = 8'h16;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT, S_DONE} state_t;
  state_t state;

  logic [31:0] cmd_q;
  logic [7:0]  stat_q;
  logic [31:0] pay_q [PAY_WORDS];

  logic [NUM_OPS-1:0] hit, len_ok;
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    assign hit[i]    = cmd_q[15:0] == OP_CODES[i*16 +: 16];
    assign len_ok[i] = hit[i] && (OP_INLEN[i*16 +: 16] == 16'hFFFF ||
                                  OP_INLEN[i*16 +: 16] == cmd_q[31:16]);
  end

  logic          in_pay;
  logic [PW-1:0] pidx;
  assign in_pay = (int'(host_addr) >= PAY_BASE) && (int'(host_addr) < PAY_BASE + PAY_WORDS);
  assign pidx   = PW'(host_addr - AW'(PAY_BASE));

  logic        out_big;
  logic [15:0] out_len_c;
  assign out_big   = hs_out_len > 16'(PAY_BYTES);
  assign out_len_c = out_big ? 16'(PAY_BYTES) : hs_out_len;

  assign hs_opcode = cmd_q[15:0];
  assign hs_in_len = cmd_q[31:16];

  always_comb begin
    host_rdata = 32'h0;
    if (host_addr == AW'(0))      host_rdata = {31'h0, doorbell};
    else if (host_addr == AW'(1)) host_rdata = cmd_q;
    else if (host_addr == AW'(2)) host_rdata = {24'h0, stat_q};
    else if (in_pay)              host_rdata = pay_q[pidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      doorbell <= 1'b0;
      hs_start <= 1'b0;
      cmd_q    <= 32'h0;
      stat_q   <= 8'h0;
      for (int k = 0; k < PAY_WORDS; k++) pay_q[k] <= 32'h0;
    end else begin
      hs_start <= 1'b0;
      case (state)
        S_IDLE: if (host_wr) begin
          if (host_addr == AW'(0) && host_wdata[0]) begin
            doorbell <= 1'b1;
            state    <= S_CHECK;
          end else if (host_addr == AW'(1)) begin
            cmd_q <= host_wdata;
          end else if (in_pay) begin
            pay_q[pidx] <= host_wdata;
          end
        end
        S_CHECK: begin
          if (|len_ok) begin
            hs_start <= 1'b1;
            state    <= S_WAIT;
          end else begin
            stat_q <= (|hit) ? RC_BADLEN : RC_UNSUP;
            cmd_q  <= 32'h0;
            state  <= S_DONE;
          end
        end
        S_WAIT: if (hs_done) begin
          cmd_q  <= {out_len_c, 16'h0};
          stat_q <= out_big ? RC_INTERNAL : hs_rc;
          state  <= S_DONE;
        end
        default: begin
          doorbell <= 1'b0;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |=> !hs_start);
  assert_start_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |-> doorbell && state == S_WAIT);
  assert_ops_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DONE |-> cmd_q[15:0] == 16'h0);
  assert_release_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> $stable(cmd_q) && $stable(stat_q));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !hs_done) |=> $stable(cmd_q) && $stable(stat_q) && doorbell);
  assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DONE |-> cmd_q[31:16] <= 16'(PAY_BYTES));
endmodule

// File: tb/test_mbox_dispatch.sv
module test_mbox_dispatch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic doorbell, hs_start;
  logic [15:0] hs_opcode, hs_in_len;
  logic hs_done = 1'b0;
  logic [7:0] hs_rc = 8'h0;
  logic [15:0] hs_out_len = 16'h0;

  always #10 clk = ~clk;

  mbox_dispatch i_mbox_dispatch (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .doorbell(doorbell),
    .hs_start(hs_start), .hs_opcode(hs_opcode), .hs_in_len(hs_in_len),
    .hs_done(hs_done), .hs_rc(hs_rc), .hs_out_len(hs_out_len));

  int total = 0, bad = 0;
  bit fin = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model
  int m_st = 0;
  bit m_db = 0, m_start = 0;
  logic [31:0] m_cmd = 0;
  logic [7:0] m_stat = 0;
  logic [31:0] m_pay [8];

  function automatic int exp_inlen(logic [15:0] op);
    case (op)
      16'h0100: return 1;
      16'h0101: return 65535;
      16'h0301: return 8;
      16'h4102: return 8;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a == 0) return {31'h0, m_db};
    if (a == 1) return m_cmd;
    if (a == 2) return {24'h0, m_stat};
    if (a >= 4 && a < 12) return m_pay[a-4];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_db = 0; m_start = 0; m_cmd = 0; m_stat = 0;
      for (int k = 0; k < 8; k++) m_pay[k] = 0;
    end else begin
      m_start = 0;
      if (m_st == 0) begin
        if (host_wr) begin
          if (host_addr == 0 && host_wdata[0]) begin m_db = 1; m_st = 1; end
          else if (host_addr == 1) m_cmd = host_wdata;
          else if (host_addr >= 4 && host_addr < 12) m_pay[host_addr-4] = host_wdata;
        end
      end else if (m_st == 1) begin
        int e;
        e = exp_inlen(m_cmd[15:0]);
        if (e == 65535 || (e >= 0 && e == int'(m_cmd[31:16]))) begin m_start = 1; m_st = 2; end
        else begin m_stat = (e < 0) ? 8'h03 : 8'h16; m_cmd = 0; m_st = 3; end
      end else if (m_st == 2) begin
        if (hs_done) begin
          if (hs_out_len > 32) begin m_cmd = {16'd32, 16'h0}; m_stat = 8'h04; end
          else begin m_cmd = {hs_out_len, 16'h0}; m_stat = hs_rc; end
          m_st = 3;
        end
      end else begin
        m_db = 0; m_st = 0;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !fin) begin
      chk(doorbell === m_db, cur_req, "doorbell", {31'h0, doorbell}, {31'h0, m_db});
      chk(hs_start === m_start, cur_req, "hs_start", {31'h0, hs_start}, {31'h0, m_start});
      chk(host_rdata === m_read(host_addr), cur_req, "rdata", host_rdata, m_read(host_addr));
      if (m_start)
        chk({hs_in_len, hs_opcode} === m_cmd, cur_req, "start fields", {hs_in_len, hs_opcode}, m_cmd);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk); host_addr = a;
    #1 chk(host_rdata === exp, req, "readback", host_rdata, exp);
  endtask

  // issue a command; accepted=1 means the stub answers with rc/olen
  task automatic do_cmd(logic [15:0] op, logic [15:0] len, bit accepted,
                        logic [7:0] rc, logic [15:0] olen, bit pokes);
    int n;
    wr(4'd1, {len, op});
    wr(4'd0, 32'h1);
    host_addr = 4'd1;
    if (accepted) begin
      n = 0;
      while (!hs_start && n < 20) begin @(posedge clk); #5; n++; end
      chk(hs_start === 1'b1, "R5", "start seen", {31'h0, hs_start}, 32'h1);
      chk(n == 1, "R5", "start latency", n, 1);
      if (pokes) begin
        wr(4'd1, 32'hFFFF_0200);
        wr(4'd4, 32'hDEAD_BEEF);
        wr(4'd0, 32'h1);
        host_addr = 4'd1;
      end
      @(negedge clk); hs_done = 1; hs_rc = rc; hs_out_len = olen;
      @(posedge clk); #5;
      chk(doorbell === 1'b1, "R7", "doorbell at writeback", {31'h0, doorbell}, 32'h1);
      @(negedge clk); hs_done = 0;
      @(posedge clk); #5;
      chk(doorbell === 1'b0, "R7", "doorbell released", {31'h0, doorbell}, 32'h0);
    end else begin
      n = 0;
      while ((doorbell || n == 0) && n < 20) begin @(posedge clk); #5; n++; end
      chk(doorbell === 1'b0, cur_req, "reject done", {31'h0, doorbell}, 32'h0);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!fin) begin
      fin = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd_chk(4'd0, 32'h0, "R1");
    rd_chk(4'd1, 32'h0, "R1");
    rd_chk(4'd2, 32'h0, "R1");
    rd_chk(4'd5, 32'h0, "R1");

    cur_req = "R2";
    do_cmd(16'h0200, 16'd0, 0, 0, 0, 0);
    rd_chk(4'd2, 32'h03, "R2");
    rd_chk(4'd1, 32'h0, "R2");
    do_cmd(16'h0001, 16'd1, 0, 0, 0, 0);
    rd_chk(4'd2, 32'h03, "R2");

    cur_req = "R3";
    do_cmd(16'h0100, 16'd2, 0, 0, 0, 0);
    rd_chk(4'd2, 32'h16, "R3");
    rd_chk(4'd1, 32'h0, "R3");

    cur_req = "R6";
    do_cmd(16'h0100, 16'd1, 1, 8'h00, 16'h20, 0);
    rd_chk(4'd1, 32'h0020_0000, "R6");
    rd_chk(4'd2, 32'h00, "R6");

    cur_req = "R4";
    do_cmd(16'h0101, 16'h0123, 1, 8'h02, 16'h0, 0);
    rd_chk(4'd2, 32'h02, "R4");
    do_cmd(16'h0101, 16'h0000, 1, 8'h00, 16'h4, 0);
    rd_chk(4'd1, 32'h0004_0000, "R4");

    cur_req = "R6";
    do_cmd(16'h4102, 16'd8, 1, 8'h04, 16'h4, 0);
    rd_chk(4'd1, 32'h0004_0000, "R6");
    rd_chk(4'd2, 32'h04, "R6");

    cur_req = "R9";
    do_cmd(16'h0301, 16'd8, 1, 8'h00, 16'd32, 0);
    rd_chk(4'd1, 32'h0020_0000, "R9");
    rd_chk(4'd2, 32'h00, "R9");
    do_cmd(16'h0301, 16'd8, 1, 8'h00, 16'd33, 0);
    rd_chk(4'd1, 32'h0020_0000, "R9");
    rd_chk(4'd2, 32'h04, "R9");

    cur_req = "R8";
    wr(4'd4, 32'hA5A5_5A5A);
    rd_chk(4'd4, 32'hA5A5_5A5A, "R8");
    do_cmd(16'h4102, 16'd8, 1, 8'h00, 16'd12, 1);
    rd_chk(4'd4, 32'hA5A5_5A5A, "R8");
    rd_chk(4'd1, 32'h000C_0000, "R8");
    rd_chk(4'd0, 32'h0, "R8");

    cur_req = "R10";
    @(negedge clk); hs_done = 1; hs_rc = 8'h55; hs_out_len = 16'd3;
    @(negedge clk); hs_done = 0;
    rd_chk(4'd1, 32'h000C_0000, "R10");
    rd_chk(4'd2, 32'h00, "R10");
    rd_chk(4'd0, 32'h0, "R10");

    repeat (3) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule